// File: doc/BRIEF.md
# Linear PE Chain with Transparent Bypass

This block is the neighbour interconnect for one row of processing elements in a data-parallel array. Every PE drives a value onto the row and raises an enable bit that says whether it takes part in the chain. When a shift is strobed, each participating PE captures the outgoing value of the closest participating PE on the chosen side. Non-participating PEs are stepped over, so PEs that sit far apart in the row can be logical neighbours. A typical use sets the enable bits from the responders of the last associative search. The non-responders then drop out of the chain.

Each PE has a small source switch. It picks the value the PE sends: its own register, the row-wide broadcast word or the instruction immediate. The received word and a received-valid flag are held per PE in a register until the next shift that involves that PE. The path that skips disabled PEs is combinational along the full row, so its delay grows with the number of PEs.

Top module: `pe_bypass_chain`

## Requirements
- R1: After a synchronous active-low reset, every PE's received word is 0 and every received-valid flag is 0.
- R2: In a cycle with `shift_i` low, no received word and no valid flag changes, whatever the other inputs do.
- R3: With `dir_i` = 0 (toward higher index), a shift gives each enabled PE i the outgoing value of the enabled PE with the largest index below i, and sets its valid flag. Disabled PEs in between are skipped.
- R4: With `dir_i` = 1 (toward lower index), a shift gives each enabled PE i the outgoing value of the enabled PE with the smallest index above i, and sets its valid flag.
- R5: An enabled PE that has no enabled PE on the source side receives 0 and has its valid flag cleared by the shift.
- R6: During a shift, a PE whose enable bit is 0 keeps its received word and valid flag. Its own outgoing value reaches no other PE.
- R7: With `src_sel_i` = 2'b00, the outgoing value of PE j is its register word `pe_data_i[j*W +: W]`.
- R8: With `src_sel_i` = 2'b01, every PE sends `bcast_i`. With 2'b10, every PE sends `imm_i`.
- R9: With `src_sel_i` = 2'b11 (reserved), every PE sends 0. The valid flag still follows R3 to R5.
- R10: Data and enable for PE i sit at `pe_data_i[i*W +: W]` and `pe_en_i[i]`. The received word and flag sit at `rx_data_o[i*W +: W]` and `rx_valid_o[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pe_data_i | input | N*W | Register word of each PE |
| pe_en_i | input | N | Per-PE chain participation |
| bcast_i | input | W | Row-wide broadcast word |
| imm_i | input | W | Instruction immediate word |
| dir_i | input | 1 | 0 = toward higher index, 1 = toward lower index |
| src_sel_i | input | 2 | Outgoing source: 00 reg, 01 broadcast, 10 immediate, 11 zero |
| shift_i | input | 1 | Shift strobe |
| rx_data_o | output | N*W | Received word of each PE |
| rx_valid_o | output | N | Received-valid flag of each PE |

## Verification
In a single shift, some PEs take words across gaps of bypassed PEs, the edge PE of the chain is zero-filled and invalidated, and disabled PEs hold their contents. The bench provokes this with sparse enable patterns in both directions, with the first and last PEs of the row disabled. A further pattern has one lone enabled PE. Every PE's word and flag are compared with a model that searches outward from each PE for its nearest enabled source, one cycle after the strobe.

// File: rtl/pe_chain_pkg.sv
// Package: shared encodings for the PE chain.
// Assumes: source select is a 2-bit field decoded by every PE switch.
package pe_chain_pkg;
    typedef enum logic [1:0] {
        SRC_REG   = 2'b00,
        SRC_BCAST = 2'b01,
        SRC_IMM   = 2'b10,
        SRC_NONE  = 2'b11
    } src_sel_e;
endpackage

// File: rtl/pe_data_switch.sv
// Module: per-PE source switch. Chooses the word a PE drives onto the chain.
// Assumes: sel is stable for the cycle. The reserved code drives zero.
module pe_data_switch
    import pe_chain_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] reg_i,
    input  logic [W-1:0] bcast_i,
    input  logic [W-1:0] imm_i,
    input  logic [1:0]   sel_i,
    output logic [W-1:0] out_o
);
    // Decode the source select into the outgoing word
    always_comb begin
        unique case (src_sel_e'(sel_i))
            SRC_REG:   out_o = reg_i;
            SRC_BCAST: out_o = bcast_i;
            SRC_IMM:   out_o = imm_i;
            default:   out_o = '0;
        endcase
    end
endmodule

// File: rtl/pe_link_scan.sv
// Module: combinational bypass scan along the row. For every PE it finds the
// nearest enabled PE on the source side and forwards that PE's word.
// Assumes: delay is linear in N; no pipelining of the chain.
module pe_link_scan #(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic [N*W-1:0] out_i,
    input  logic [N-1:0]   en_i,
    input  logic           dir_i,
    output logic [N*W-1:0] nb_data_o,
    output logic [N-1:0]   nb_valid_o
);
    logic [W-1:0] up_d   [N];
    logic         up_v   [N];
    logic [W-1:0] dn_d   [N];
    logic         dn_v   [N];

    // Scan upward: carry the last enabled word seen from index 0
    always_comb begin
        logic [W-1:0] run_d;
        logic         run_v;
        run_d = '0;
        run_v = 1'b0;
        for (int i = 0; i < N; i++) begin
            up_d[i] = run_d;
            up_v[i] = run_v;
            if (en_i[i]) begin
                run_d = out_i[i*W +: W];
                run_v = 1'b1;
            end
        end
    end

    // Scan downward: carry the last enabled word seen from index N-1
    always_comb begin
        logic [W-1:0] run_d;
        logic         run_v;
        run_d = '0;
        run_v = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            dn_d[i] = run_d;
            dn_v[i] = run_v;
            if (en_i[i]) begin
                run_d = out_i[i*W +: W];
                run_v = 1'b1;
            end
        end
    end

    // Pick the scan that matches the shift direction
    always_comb begin
        for (int i = 0; i < N; i++) begin
            nb_data_o[i*W +: W] = dir_i ? dn_d[i] : up_d[i];
            nb_valid_o[i]       = dir_i ? dn_v[i] : up_v[i];
        end
    end
endmodule

// File: rtl/pe_rx_slot.sv
// Module: per-PE receive register. Captures the neighbour word and flag
// when loaded, holds otherwise.
// Assumes: load already combines the shift strobe and the PE enable.
module pe_rx_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] nb_data_i,
    input  logic         nb_valid_i,
    output logic [W-1:0] rx_data_o,
    output logic         rx_valid_o
);
    // Hold or capture the received word and flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data_o  <= '0;
            rx_valid_o <= 1'b0;
        end else if (load_i) begin
            rx_data_o  <= nb_data_i;
            rx_valid_o <= nb_valid_i;
        end
    end

    // R2
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(rx_data_o) && $stable(rx_valid_o)));

    // R5
    slot_nosrc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !nb_valid_i) |=> (!rx_valid_o && rx_data_o == '0));
endmodule

// File: rtl/pe_bypass_chain.sv
// Module: top of the linear PE chain with bypass. Per-PE source switches
// feed a combinational bypass scan, and its result is registered per PE on a shift.
// Assumes: PE i is at slice i of every flattened port; dir 0 moves words
// toward higher index.
module pe_bypass_chain #(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N*W-1:0] pe_data_i,
    input  logic [N-1:0]   pe_en_i,
    input  logic [W-1:0]   bcast_i,
    input  logic [W-1:0]   imm_i,
    input  logic           dir_i,
    input  logic [1:0]     src_sel_i,
    input  logic           shift_i,
    output logic [N*W-1:0] rx_data_o,
    output logic [N-1:0]   rx_valid_o
);
    localparam int TOP = N - 1;

    logic [N*W-1:0] out_w;
    logic [N*W-1:0] nb_data_w;
    logic [N-1:0]   nb_valid_w;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_pe
            pe_data_switch #(.W(W)) u_sw (
                .reg_i   (pe_data_i[g*W +: W]),
                .bcast_i (bcast_i),
                .imm_i   (imm_i),
                .sel_i   (src_sel_i),
                .out_o   (out_w[g*W +: W])
            );

            pe_rx_slot #(.W(W)) u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .load_i     (shift_i & pe_en_i[g]),
                .nb_data_i  (nb_data_w[g*W +: W]),
                .nb_valid_i (nb_valid_w[g]),
                .rx_data_o  (rx_data_o[g*W +: W]),
                .rx_valid_o (rx_valid_o[g])
            );

            // R6
            dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (shift_i && !pe_en_i[g]) |=>
                    ($stable(rx_data_o[g*W +: W]) && $stable(rx_valid_o[g])));

            // R9
            rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (shift_i && pe_en_i[g] && src_sel_i == 2'b11) |=>
                    (rx_data_o[g*W +: W] == '0));

            // R8
            bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (shift_i && pe_en_i[g] && src_sel_i == 2'b01) |=>
                    (!rx_valid_o[g] || rx_data_o[g*W +: W] == $past(bcast_i)));
        end
    endgenerate

    pe_link_scan #(.N(N), .W(W)) u_scan (
        .out_i      (out_w),
        .en_i       (pe_en_i),
        .dir_i      (dir_i),
        .nb_data_o  (nb_data_w),
        .nb_valid_o (nb_valid_w)
    );

    // R5
    edge_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && pe_en_i[0] && !dir_i) |=>
            (!rx_valid_o[0] && rx_data_o[W-1:0] == '0));

    // R5
    edge_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && pe_en_i[TOP] && dir_i) |=>
            (!rx_valid_o[TOP] && rx_data_o[TOP*W +: W] == '0));
endmodule

// File: tb/pe_bypass_chain_bench.sv
module pe_bypass_chain_bench;
    localparam int N = 8;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N*W-1:0] pe_data = '0;
    logic [N-1:0]   pe_en = '0;
    logic [W-1:0]   bcast = '0;
    logic [W-1:0]   imm = '0;
    logic           dir = 1'b0;
    logic [1:0]     sel = 2'b00;
    logic           shift = 1'b0;
    logic [N*W-1:0] rx_data;
    logic [N-1:0]   rx_valid;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic [N*W-1:0] exp_data = '0;
    logic [N-1:0]   exp_valid = '0;

    always #10 clk = ~clk;

    pe_bypass_chain #(.N(N), .W(W)) u_pe_bypass_chain (
        .clk(clk), .rst_n(rst_n), .pe_data_i(pe_data), .pe_en_i(pe_en),
        .bcast_i(bcast), .imm_i(imm), .dir_i(dir), .src_sel_i(sel),
        .shift_i(shift), .rx_data_o(rx_data), .rx_valid_o(rx_valid)
    );

    function automatic logic [W-1:0] src_word(int j);
        case (sel)
            2'b00:   return pe_data[j*W +: W];
            2'b01:   return bcast;
            2'b10:   return imm;
            default: return '0;
        endcase
    endfunction

    // Model: search outward from each enabled PE for its nearest enabled source
    task automatic model_step();
        logic [N*W-1:0] nd;
        logic [N-1:0]   nv;
        nd = exp_data;
        nv = exp_valid;
        if (shift) begin
            for (int i = 0; i < N; i++) begin
                if (pe_en[i]) begin
                    int src;
                    src = -1;
                    if (!dir) begin
                        for (int j = i - 1; j >= 0; j--)
                            if (src < 0 && pe_en[j]) src = j;
                    end else begin
                        for (int j = i + 1; j < N; j++)
                            if (src < 0 && pe_en[j]) src = j;
                    end
                    if (src < 0) begin
                        nd[i*W +: W] = '0;
                        nv[i] = 1'b0;
                    end else begin
                        nd[i*W +: W] = src_word(src);
                        nv[i] = 1'b1;
                    end
                end
            end
        end
        exp_data = nd;
        exp_valid = nv;
    endtask

    task automatic compare(string tag);
        vectors++;
        if (rx_data !== exp_data || rx_valid !== exp_valid) begin
            miscompares++;
            $display("FAIL %s: data=%h valid=%b expected data=%h valid=%b",
                     tag, rx_data, rx_valid, exp_data, exp_valid);
        end
    endtask

    // Drive one cycle of inputs, update the model, check after the edge
    task automatic apply(logic [N-1:0] en, logic d, logic [1:0] s, logic sh, string tag);
        pe_en = en; dir = d; sel = s; shift = sh;
        model_step();
        @(posedge clk);
        #5;
        compare(tag);
    endtask

    task automatic load_regs(int seed);
        for (int i = 0; i < N; i++) pe_data[i*W +: W] = W'(seed + i * 17);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        exp_data = '0; exp_valid = '0;
        compare("R1 reset state");
        rst_n = 1'b1;
    endtask

    task automatic t_right_full();
        load_regs(3);
        apply(8'hFF, 1'b0, 2'b00, 1'b1, "R3 R7 R10 right shift all enabled");
    endtask

    task automatic t_left_full();
        load_regs(40);
        apply(8'hFF, 1'b1, 2'b00, 1'b1, "R4 R7 left shift all enabled");
    endtask

    task automatic t_gap_right();
        load_regs(90);
        apply(8'b0101_0010, 1'b0, 2'b00, 1'b1, "R3 R5 R6 right shift across gaps");
    endtask

    task automatic t_gap_left();
        load_regs(130);
        apply(8'b0110_0100, 1'b1, 2'b00, 1'b1, "R4 R5 R6 left shift across gaps");
    endtask

    task automatic t_bcast();
        bcast = 8'hA5;
        apply(8'b1011_0110, 1'b0, 2'b01, 1'b1, "R8 broadcast source");
    endtask

    task automatic t_imm();
        imm = 8'h3C;
        apply(8'b1110_1101, 1'b1, 2'b10, 1'b1, "R8 immediate source");
    endtask

    task automatic t_rsvd();
        load_regs(7);
        apply(8'hFF, 1'b0, 2'b00, 1'b1, "R7 reload before reserved");
        apply(8'b0111_1110, 1'b0, 2'b11, 1'b1, "R9 reserved source drives zero");
    endtask

    task automatic t_hold();
        load_regs(200);
        bcast = 8'h11;
        apply(8'hFF, 1'b0, 2'b00, 1'b0, "R2 no shift all enabled");
        apply(8'h00, 1'b1, 2'b01, 1'b0, "R2 no shift inputs changed");
    endtask

    task automatic t_none();
        load_regs(55);
        apply(8'h00, 1'b0, 2'b00, 1'b1, "R6 shift with no PE enabled");
    endtask

    task automatic t_single();
        apply(8'b0001_0000, 1'b1, 2'b00, 1'b1, "R5 lone enabled PE left");
        apply(8'b0000_0001, 1'b0, 2'b00, 1'b1, "R5 lone enabled PE0 right");
    endtask

    task automatic t_back_to_back();
        load_regs(17);
        apply(8'b1100_0011, 1'b0, 2'b00, 1'b1, "R3 back-to-back shift 1");
        load_regs(71);
        apply(8'b1100_0011, 1'b1, 2'b00, 1'b1, "R4 back-to-back shift 2");
    endtask

    initial begin
        #1;
        t_reset();
        t_right_full();
        t_left_full();
        t_gap_right();
        t_gap_left();
        t_bcast();
        t_imm();
        t_rsvd();
        t_hold();
        t_none();
        t_single();
        t_back_to_back();
        t_reset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule